// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register interface that sits between a host bus and a three-channel interval timer. The host reaches it through a 2-bit address: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the command port. Command bytes either reconfigure a channel, freeze that channel's live count, or, as a read-back command, freeze the count and/or the status of any subset of channels in one write. Sixteen-bit counts travel as low byte only, high byte only, or low byte followed by high byte, as each channel's access setting selects.

Toward the counters, the block issues a one-cycle load strobe per channel. The strobe carries the fully assembled 16-bit count and the channel's configured mode. The block samples each channel's live count and output level. The counters themselves are outside this block. Read data is combinational while the read strobe is high. All state moves on the rising clock edge of the strobe cycle.

Top module: `timer_host_regif`

## Requirements
- R1: After synchronous reset, no load strobe is active, no count or status snapshot is pending, and both byte toggles are in the low-byte state. Each channel has access setting 3 (word), mode 0 and BCD 0, with its null-count flag set. A status read-back of every channel then returns 0x70 with bit 7 equal to that channel's output.
- R2: A command-port write with bits 7:6 equal to 0, 1 or 2 and a nonzero bits 5:4 does four things to the selected channel. It stores bits 5:4 as the access setting (1 = low byte, 2 = high byte, 3 = low then high), bits 3:1 as the mode and bit 0 as BCD. It returns both byte toggles to the low-byte state, including discarding a held low byte. It sets the null-count flag. It never produces a load strobe.
- R3: With access 1, a data-port write of byte D loads 0x00D; with access 2 it loads D shifted left by eight with a zero low byte. The strobe bit of that channel, the count and the stored mode appear in the cycle after the write edge, for one cycle.
- R4: With access 3, the first data-port write is held with no strobe. The second loads {second byte, first byte}, and the toggle then returns to the low-byte state.
- R5: With no snapshot pending, a data-port read returns the live count's low byte for access 1 and its high byte for access 2. For access 3 it returns the low byte and the high byte alternately, starting with the low byte.
- R6: A command-port write with bits 7:6 = channel and bits 5:4 = 0 snapshots that channel's live count at that edge without changing its configuration. Reads then return the snapshot by access setting: low byte, high byte, or low then high. The snapshot is freed after its last byte, and later reads return the live count again.
- R7: A count snapshot request, from either command form, is ignored while a previous count snapshot of that channel is still unread. The same holds for a status snapshot request while a status snapshot is unread.
- R8: A command byte with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 requests a count snapshot and bit 4 = 0 requests a status snapshot for every selected channel in the same edge.
- R9: The status snapshot byte has the channel output sampled at the command edge in bit 7 and the null-count flag in bit 6. Bits 5:4 hold the access setting, bits 3:1 the mode and bit 0 the BCD bit. The null-count flag clears in the edge that completes a count load.
- R10: A pending status snapshot is returned before a pending count snapshot, and reading it frees only the status snapshot.
- R11: At most one load strobe bit is high in a cycle, and a strobe appears only in the cycle after a data-port write.
- R12: A read of address 3 returns 0x00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | 0..2 channel data port, 3 command port |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while rd_en is high, zero otherwise |
| live_cnt | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| chan_out | input | 3 | Output level of each channel |
| ld_stb | output | 3 | One-cycle count load strobe per channel |
| ld_count | output | 16 | Assembled count for the strobed channel, zero without a strobe |
| ld_mode | output | 3 | Configured mode of the strobed channel, zero without a strobe |

## Verification
Directed sequences first walk each access setting through writes and live reads. This separates low-only, high-only and word assembly, and shows the toggle restarting after a reconfiguration. Snapshot cases change the live count and the output level between the command and the reads, so a snapshot taken at the wrong edge, or a second request wrongly accepted, shows up as a different value. Read-back commands that combine status and count on one channel, or cover several channels at once, distinguish the status-before-count order and the channel select bits. A long run of random command, data, read and live-count changes is then scored against a byte-level model of every channel, which mixes interleavings that the directed cases do not reach.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;

    localparam int NCH      = 3;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int MODE_W   = 3;
    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(NCH);

    // access setting of a channel: how 16-bit values are split into bytes
    typedef enum logic [1:0] {
        ACC_SNAP = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    // state of a frozen count waiting to be read
    typedef enum logic [2:0] {
        SNAP_NONE = 3'd0,
        SNAP_LO   = 3'd1,
        SNAP_HI   = 3'd2,
        SNAP_W0   = 3'd3,
        SNAP_W1   = 3'd4
    } snap_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chcfg_t;

    localparam chcfg_t CFG_RESET = '{acc: ACC_WORD, mode: '0, bcd: 1'b0};

    // per-channel strobes produced by the command decoder
    typedef struct packed {
        logic [NCH-1:0] cfg_we;
        logic [NCH-1:0] snap_cnt;
        logic [NCH-1:0] snap_st;
        logic [NCH-1:0] dat_we;
        logic [NCH-1:0] dat_re;
        chcfg_t         cfg;
    } regif_cmd_t;

    function automatic snap_e snap_kind(acc_e a);
        case (a)
            ACC_LO:  return SNAP_LO;
            ACC_HI:  return SNAP_HI;
            default: return SNAP_W0;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(logic o, logic nul, chcfg_t c);
        return {o, nul, c};
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(logic [CNT_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(logic [CNT_W-1:0] v);
        return v[CNT_W-1:BYTE_W];
    endfunction

endpackage

// File: rtl/timer_regif_decode.sv
module timer_regif_decode
    import timer_regif_pkg::*;
(
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    output regif_cmd_t          cmd
);

    localparam logic [1:0] SEL_RB = 2'd3;

    logic       is_cmd;
    logic [1:0] sel;
    acc_e       acc;
    logic       is_rb;
    logic       rb_cnt;
    logic       rb_st;

    assign is_cmd = wr_en && (addr == CMD_ADDR);
    assign sel    = wdata[7:6];
    assign acc    = acc_e'(wdata[5:4]);
    assign is_rb  = (sel == SEL_RB);
    // read-back request flags are active low
    assign rb_cnt = !wdata[5];
    assign rb_st  = !wdata[4];

    always_comb begin
        cmd          = '0;
        cmd.cfg.acc  = acc;
        cmd.cfg.mode = wdata[3:1];
        cmd.cfg.bcd  = wdata[0];
        for (int c = 0; c < NCH; c++) begin
            cmd.cfg_we[c]   = is_cmd && !is_rb && (sel == 2'(c)) && (acc != ACC_SNAP);
            cmd.snap_cnt[c] = is_cmd && ((!is_rb && (sel == 2'(c)) && (acc == ACC_SNAP)) ||
                                         (is_rb && wdata[c+1] && rb_cnt));
            cmd.snap_st[c]  = is_cmd && is_rb && wdata[c+1] && rb_st;
            cmd.dat_we[c]   = wr_en && (addr == ADDR_W'(c));
            cmd.dat_re[c]   = rd_en && (addr == ADDR_W'(c));
        end
    end

endmodule

// File: rtl/timer_regif_chan.sv
module timer_regif_chan
    import timer_regif_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  chcfg_t              cfg_in,
    input  logic                snap_cnt,
    input  logic                snap_st,
    input  logic                dat_we,
    input  logic                dat_re,
    input  logic [BYTE_W-1:0]   wbyte,
    input  logic [CNT_W-1:0]    live,
    input  logic                out_lvl,
    output logic [BYTE_W-1:0]   rbyte,
    output logic                ld_stb,
    output logic [CNT_W-1:0]    ld_val,
    output logic [MODE_W-1:0]   ld_mode
);

    chcfg_t              cfg_q;
    logic                wr_hi_q;
    logic                rd_hi_q;
    logic [BYTE_W-1:0]   hold_q;
    logic                null_q;
    snap_e               snap_q;
    logic [CNT_W-1:0]    snap_val_q;
    logic                st_pend_q;
    logic [BYTE_W-1:0]   st_val_q;
    logic                ld_stb_q;
    logic [CNT_W-1:0]    ld_val_q;
    logic [MODE_W-1:0]   ld_mode_q;

    logic                load_now;
    logic [CNT_W-1:0]    load_val;

    // count assembly from data-port bytes
    always_comb begin
        load_now = 1'b0;
        load_val = '0;
        case (cfg_q.acc)
            ACC_LO: begin
                load_now = dat_we;
                load_val = {{BYTE_W{1'b0}}, wbyte};
            end
            ACC_HI: begin
                load_now = dat_we;
                load_val = {wbyte, {BYTE_W{1'b0}}};
            end
            ACC_WORD: begin
                load_now = dat_we && wr_hi_q;
                load_val = {wbyte, hold_q};
            end
            default: begin
                load_now = 1'b0;
                load_val = '0;
            end
        endcase
    end

    // read byte: status snapshot, then count snapshot, then live count
    always_comb begin
        if (st_pend_q) begin
            rbyte = st_val_q;
        end else begin
            case (snap_q)
                SNAP_LO, SNAP_W0: rbyte = lo_byte(snap_val_q);
                SNAP_HI, SNAP_W1: rbyte = hi_byte(snap_val_q);
                default: begin
                    case (cfg_q.acc)
                        ACC_HI:   rbyte = hi_byte(live);
                        ACC_WORD: rbyte = rd_hi_q ? hi_byte(live) : lo_byte(live);
                        default:  rbyte = lo_byte(live);
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= CFG_RESET;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            hold_q     <= '0;
            null_q     <= 1'b1;
            snap_q     <= SNAP_NONE;
            snap_val_q <= '0;
            st_pend_q  <= 1'b0;
            st_val_q   <= '0;
            ld_stb_q   <= 1'b0;
            ld_val_q   <= '0;
            ld_mode_q  <= '0;
        end else begin
            ld_stb_q <= load_now;
            if (load_now) begin
                ld_val_q  <= load_val;
                ld_mode_q <= cfg_q.mode;
            end

            if (cfg_we) begin
                cfg_q   <= cfg_in;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
                null_q  <= 1'b1;
            end else begin
                if (dat_we && (cfg_q.acc == ACC_WORD)) begin
                    if (!wr_hi_q) begin
                        hold_q  <= wbyte;
                        wr_hi_q <= 1'b1;
                    end else begin
                        wr_hi_q <= 1'b0;
                    end
                end
                if (load_now) begin
                    null_q <= 1'b0;
                end
            end

            if (dat_re) begin
                if (st_pend_q) begin
                    st_pend_q <= 1'b0;
                end else if (snap_q != SNAP_NONE) begin
                    snap_q <= (snap_q == SNAP_W0) ? SNAP_W1 : SNAP_NONE;
                end else if (cfg_q.acc == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                end
            end

            if (snap_cnt && (snap_q == SNAP_NONE)) begin
                snap_q     <= snap_kind(cfg_q.acc);
                snap_val_q <= live;
            end
            if (snap_st && !st_pend_q) begin
                st_pend_q <= 1'b1;
                st_val_q  <= status_byte(out_lvl, null_q, cfg_q);
            end
        end
    end

    assign ld_stb  = ld_stb_q;
    assign ld_val  = ld_val_q;
    assign ld_mode = ld_mode_q;

endmodule

// File: rtl/timer_host_regif.sv
module timer_host_regif
    import timer_regif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [BYTE_W-1:0]       rdata,
    input  logic [NCH*CNT_W-1:0]    live_cnt,
    input  logic [NCH-1:0]          chan_out,
    output logic [NCH-1:0]          ld_stb,
    output logic [CNT_W-1:0]        ld_count,
    output logic [MODE_W-1:0]       ld_mode
);

    regif_cmd_t          cmd;
    logic [BYTE_W-1:0]   ch_rbyte [NCH];
    logic [NCH-1:0]      ch_stb;
    logic [CNT_W-1:0]    ch_val   [NCH];
    logic [MODE_W-1:0]   ch_mode  [NCH];

    timer_regif_decode u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .cmd   (cmd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        timer_regif_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cmd.cfg_we[c]),
            .cfg_in   (cmd.cfg),
            .snap_cnt (cmd.snap_cnt[c]),
            .snap_st  (cmd.snap_st[c]),
            .dat_we   (cmd.dat_we[c]),
            .dat_re   (cmd.dat_re[c]),
            .wbyte    (wdata),
            .live     (live_cnt[c*CNT_W +: CNT_W]),
            .out_lvl  (chan_out[c]),
            .rbyte    (ch_rbyte[c]),
            .ld_stb   (ch_stb[c]),
            .ld_val   (ch_val[c]),
            .ld_mode  (ch_mode[c])
        );
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_en && (addr == ADDR_W'(c))) begin
                rdata = ch_rbyte[c];
            end
        end
    end

    always_comb begin
        ld_count = '0;
        ld_mode  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_stb[c]) begin
                ld_count = ld_count | ch_val[c];
                ld_mode  = ld_mode | ch_mode[c];
            end
        end
    end

    assign ld_stb = ch_stb;

endmodule

// File: rtl/timer_regif_chk.sv
module timer_regif_chk
    import timer_regif_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    addr,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [BYTE_W-1:0]    rdata,
    input logic [NCH-1:0]       ld_stb
);

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_stb)); // R11

    AST_LOAD_AFTER_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|ld_stb) |-> $past(wr_en && (addr != CMD_ADDR))); // R11

    AST_CMD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == CMD_ADDR)) |=> (ld_stb == '0)); // R2

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (ld_stb == '0)); // R3

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == CMD_ADDR)) |-> (rdata == '0)); // R12

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ld_stb == '0)); // R1

endmodule

bind timer_host_regif timer_regif_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rdata  (rdata),
    .ld_stb (ld_stb)
);

// File: tb/tb_timer_host_regif.sv
`timescale 1ns/1ps
module tb_timer_host_regif;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  addr;
    logic        wr_en;
    logic        rd_en;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [47:0] live_cnt;
    logic [2:0]  chan_out;
    logic [2:0]  ld_stb;
    logic [15:0] ld_count;
    logic [2:0]  ld_mode;

    always #2.5 clk = ~clk;

    timer_host_regif dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .chan_out(chan_out),
        .ld_stb(ld_stb), .ld_count(ld_count), .ld_mode(ld_mode)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of each channel, built from the requirements
    int          m_acc [3];
    int          m_mode[3];
    int          m_bcd [3];
    bit          m_wh  [3];
    bit          m_rh  [3];
    logic [7:0]  m_hold[3];
    bit          m_null[3];
    int          m_cl  [3];   // 0 none, 1 lo, 2 hi, 3 word lo next, 4 word hi next
    logic [15:0] m_cv  [3];
    bit          m_sp  [3];
    logic [7:0]  m_sv  [3];
    logic [15:0] m_live[3];
    bit          m_out [3];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lo8(logic [15:0] v); return v[7:0]; endfunction
    function automatic logic [7:0] hi8(logic [15:0] v); return v[15:8]; endfunction

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0;
            m_wh[c] = 0; m_rh[c] = 0; m_hold[c] = 0; m_null[c] = 1;
            m_cl[c] = 0; m_cv[c] = 0; m_sp[c] = 0; m_sv[c] = 0;
        end
    endtask

    task automatic set_live(input int c, input logic [15:0] v, input bit o);
        m_live[c] = v;
        m_out[c]  = o;
        live_cnt[c*16 +: 16] = v;
        chan_out[c] = o;
    endtask

    task automatic m_snap_cnt(input int c);
        if (m_cl[c] == 0) begin
            m_cv[c] = m_live[c];
            m_cl[c] = (m_acc[c] == 1) ? 1 : (m_acc[c] == 2) ? 2 : 3;
        end
    endtask

    task automatic m_snap_st(input int c);
        if (!m_sp[c]) begin
            m_sp[c] = 1;
            m_sv[c] = {m_out[c], m_null[c], 2'(m_acc[c]), 3'(m_mode[c]), 1'(m_bcd[c])};
        end
    endtask

    // one byte write; checks the load outputs in the following cycle
    task automatic do_wr(input int a, input logic [7:0] d, input string ovr);
        logic [21:0] exp;
        string tag;
        exp = '0;
        if (a == 3) begin
            tag = "R2";
            if (d[7:6] == 2'd3) begin
                for (int c = 0; c < 3; c++) begin
                    if (d[c+1]) begin
                        if (!d[5]) m_snap_cnt(c);
                        if (!d[4]) m_snap_st(c);
                    end
                end
            end else if (d[5:4] == 2'd0) begin
                m_snap_cnt(int'(d[7:6]));
            end else begin
                m_acc[d[7:6]] = int'(d[5:4]); m_mode[d[7:6]] = int'(d[3:1]);
                m_bcd[d[7:6]] = int'(d[0]);
                m_wh[d[7:6]] = 0; m_rh[d[7:6]] = 0; m_null[d[7:6]] = 1;
            end
        end else begin
            tag = "R3";
            if (m_acc[a] == 1) begin
                exp = {3'(1 << a), 3'(m_mode[a]), 8'h00, d};
                m_null[a] = 0;
            end else if (m_acc[a] == 2) begin
                exp = {3'(1 << a), 3'(m_mode[a]), d, 8'h00};
                m_null[a] = 0;
            end else begin
                tag = "R4";
                if (!m_wh[a]) begin
                    m_hold[a] = d; m_wh[a] = 1;
                end else begin
                    exp = {3'(1 << a), 3'(m_mode[a]), d, m_hold[a]};
                    m_wh[a] = 0; m_null[a] = 0;
                end
            end
        end
        if (ovr != "") tag = ovr;
        addr = 2'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check(tag, {10'd0, ld_stb, ld_mode, ld_count}, {10'd0, exp});
    endtask

    // one byte read; samples the combinational read data before the edge
    task automatic do_rd(input int a, input string ovr);
        logic [7:0] exp;
        string tag;
        addr = 2'(a); rd_en = 1'b1;
        #1;
        if (a == 3) begin
            exp = 8'h00; tag = "R12";
        end else if (m_sp[a]) begin
            exp = m_sv[a]; m_sp[a] = 0; tag = "R10";
        end else if (m_cl[a] != 0) begin
            tag = "R6";
            case (m_cl[a])
                1: begin exp = lo8(m_cv[a]); m_cl[a] = 0; end
                2: begin exp = hi8(m_cv[a]); m_cl[a] = 0; end
                3: begin exp = lo8(m_cv[a]); m_cl[a] = 4; end
                default: begin exp = hi8(m_cv[a]); m_cl[a] = 0; end
            endcase
        end else begin
            tag = "R5";
            if (m_acc[a] == 1) exp = lo8(m_live[a]);
            else if (m_acc[a] == 2) exp = hi8(m_live[a]);
            else begin
                exp = m_rh[a] ? hi8(m_live[a]) : lo8(m_live[a]);
                m_rh[a] = !m_rh[a];
            end
        end
        if (ovr != "") tag = ovr;
        check(tag, {24'd0, rdata}, {24'd0, exp});
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
        live_cnt = '0; chan_out = '0;
        set_live(0, 16'h1234, 1'b1);
        set_live(1, 16'hA5C3, 1'b0);
        set_live(2, 16'h0F0E, 1'b1);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet outputs and default status after reset
        check("R1", {26'd0, ld_stb, ld_mode}, 32'd0);
        check("R1", {24'd0, rdata}, 32'd0);
        do_wr(3, 8'hEE, "R1");
        do_rd(0, "R1"); do_rd(1, "R1"); do_rd(2, "R1");

        // R5: word access live reads alternate
        do_rd(0, ""); do_rd(0, "");

        // R3: low-only and high-only loads
        do_wr(3, 8'h54, "R2");
        do_wr(1, 8'hAB, "R3");
        do_wr(3, 8'h66, "R2");
        do_wr(1, 8'hCD, "R3");
        do_rd(1, "R5");

        // R4: word assembly
        do_wr(3, 8'hB9, "R2");
        do_wr(2, 8'h11, "R4");
        do_wr(2, 8'h22, "R4");

        // R9: null-count clear after load, set after reconfiguration
        set_live(2, 16'h0F0E, 1'b0);
        do_wr(3, 8'hE8, "R9");
        do_rd(2, "R9");
        do_wr(3, 8'hB9, "R9");
        do_wr(3, 8'hE8, "R9");
        do_rd(2, "R9");

        // R2: reconfiguration drops a held low byte
        do_wr(2, 8'h55, "R4");
        do_wr(3, 8'hB9, "R2");
        do_wr(2, 8'h33, "R2");
        do_wr(2, 8'h44, "R2");

        // R6: count snapshot in word access
        do_wr(3, 8'h00, "R6");
        set_live(0, 16'hBEEF, 1'b0);
        do_rd(0, "R6"); do_rd(0, "R6"); do_rd(0, "R6"); do_rd(0, "R6");

        // R7: second snapshot request while unread is ignored
        do_wr(3, 8'h00, "R7");
        set_live(0, 16'h7777, 1'b1);
        do_wr(3, 8'h00, "R7");
        do_wr(3, 8'hDE, "R7");
        set_live(0, 16'h9999, 1'b0);
        do_rd(0, "R7"); do_rd(0, "R7");

        // R10: status before count, repeated status request ignored
        do_wr(3, 8'hC4, "R10");
        set_live(1, 16'h4321, 1'b1);
        do_wr(3, 8'hE4, "R10");
        do_rd(1, "R10"); do_rd(1, "R10"); do_rd(1, "R10");

        // R8: count snapshot of two channels in one command
        do_wr(3, 8'hDA, "R8");
        set_live(0, 16'h0101, 1'b1);
        set_live(2, 16'h0202, 1'b1);
        do_rd(0, "R8"); do_rd(2, "R8"); do_rd(0, "R8"); do_rd(2, "R8");

        // R12: command port read, then channel state unchanged
        do_rd(3, "R12");
        do_rd(0, "R12");

        // R11: back-to-back loads on two channels
        do_wr(3, 8'h12, "R2");
        do_wr(0, 8'h01, "R11");
        do_wr(1, 8'h02, "R11");

        // random mix scored against the model
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op == 0) begin
                int c;
                c = int'($urandom_range(0, 2));
                set_live(c, 16'($urandom), 1'($urandom));
            end else if (op == 1) begin
                do_wr(3, {2'($urandom_range(0, 2)), 2'($urandom), 3'($urandom), 1'($urandom)}, "");
            end else if (op == 2) begin
                do_wr(3, {2'b11, 2'($urandom), 3'($urandom), 1'b0}, "");
            end else if (op <= 5) begin
                do_wr(int'($urandom_range(0, 2)), 8'($urandom), "");
            end else begin
                do_rd(int'($urandom_range(0, 3)), "");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule